// File: doc/BRIEF.md
# Prescaled Timer Mode Controller

This block holds an 8-bit timer mode register and turns its clock-source field into count enables for a pair of 8-bit down-counters. Three of the four source codes pick a tap of a free-running prescaler supplied from outside. Each fall of the chosen tap from 1 to 0 gives one single-cycle tick. The fourth code selects external clock pins. Each pin passes through a synchronizer and an edge detector, and the counted edge is chosen per pin.

Writing the mode register has a side effect: both counters reload to all ones, unless the remote-control flag is high. In remote-control mode the second pin always counts the edge opposite to the one chosen for the first pin. Each counter counts down and wraps, and it raises a one-cycle underflow pulse when it wraps.

Top module: `tmr_mode_ctrl`

## Requirements
- R1: After reset the stored mode bits are zero, `rd_data` reads 8'h02, both counters hold 8'hFF and both underflow pulses are low.
- R2: Bit 1 of `rd_data` always reads 1 and ignores written data. Bits 7:2 and bit 0 read back the value last written.
- R3: A write with `remote_mode` low sets both counters to 8'hFF on the clock edge that takes the write, whatever data is written.
- R4: A write with `remote_mode` high leaves both counters unchanged when no count tick occurs.
- R5: With mode bits [7:6] = 2'b00, the counters step once every 512 clocks, on each 1-to-0 fall of prescaler bit 8.
- R6: With mode bits [7:6] = 2'b01, the counters step once every 256 clocks, on each fall of prescaler bit 7.
- R7: With mode bits [7:6] = 2'b10, the counters step once every 4 clocks, on each fall of prescaler bit 1.
- R8: With mode bits [7:6] = 2'b11, counter A steps once per edge of `ext_a` and counter B once per edge of `ext_b`. The counted edge is rising when that pin's edge select is 1 and falling when it is 0. The step appears three clocks after the pin changes.
- R9: With `remote_mode` high, pin B counts the edge opposite to the one chosen by `edge_sel_a`, and `edge_sel_b` has no effect.
- R10: Each tick decrements a counter by one. A step from 8'h00 wraps to 8'hFF and raises that counter's underflow output for exactly one cycle.
- R11: When a preloading write and a tick fall in the same cycle, the counter loads 8'hFF and does not decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Mode register write strobe |
| wr_data | input | 8 | Mode register write data |
| rd_data | output | 8 | Mode register read data |
| prs_i | input | 10 | Free-running prescaler count |
| ext_a | input | 1 | External clock pin for counter A |
| ext_b | input | 1 | External clock pin for counter B |
| edge_sel_a | input | 1 | Pin A counted edge, 1 = rising |
| edge_sel_b | input | 1 | Pin B counted edge, 1 = rising |
| remote_mode | input | 1 | Remote-control mode flag |
| cnt_a | output | 8 | Counter A value |
| cnt_b | output | 8 | Counter B value |
| unf_a | output | 1 | Counter A underflow pulse |
| unf_b | output | 1 | Counter B underflow pulse |

## Verification
The hardest case to reach is the collision of a preloading write with a prescaler tick in the same cycle. The tick is internal and lasts only one cycle. The stimulus selects the divide-by-4 source and watches its own copy of the prescaler count. It raises the write strobe in the cycle in which the two low bits of that count have just become zero, which is exactly when the tap falls. The remote-mode edge inversion is reached by first preloading in normal mode and only then raising the remote flag. Each pin is then pulsed on its own, so that the edge that is counted can be told apart from the edge that is ignored.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      SRC_SLOW = 2'b00,
      SRC_MID  = 2'b01,
      SRC_FAST = 2'b10,
      SRC_EXT  = 2'b11
   } src_e;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
   import tmr_pkg::*;
#(
   parameter int PS_W     = 10,
   parameter int TAP_SLOW = 8,
   parameter int TAP_MID  = 7,
   parameter int TAP_FAST = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PS_W-1:0] prs_i,
   input  src_e            sel_i,
   output logic            tick_o
);
   localparam int NTAP = 3;
   localparam int TAPS [NTAP] = '{TAP_SLOW, TAP_MID, TAP_FAST};

   logic [NTAP-1:0] tap_now, tap_prev, tap_fall;

   for (genvar i = 0; i < NTAP; i++) begin : g_tap
      assign tap_now[i] = prs_i[TAPS[i]];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tap_prev <= '0;
      else        tap_prev <= tap_now;
   end

   assign tap_fall = tap_prev & ~tap_now;

   always_comb begin
      unique case (sel_i)
         SRC_SLOW: tick_o = tap_fall[0];
         SRC_MID:  tick_o = tap_fall[1];
         SRC_FAST: tick_o = tap_fall[2];
         default:  tick_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/tmr_ext_edge.sv
module tmr_ext_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic rise_i,
   output logic edge_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[0] <= 1'b0;
      else        sync_q[0] <= pin_i;
   end

   for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[s] <= 1'b0;
         else        sync_q[s] <= sync_q[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[SYNC_STAGES-1];
   end

   assign edge_o = rise_i ? ( sync_q[SYNC_STAGES-1] & ~last_q)
                          : (~sync_q[SYNC_STAGES-1] &  last_q);
endmodule

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic         tick_i,
   output logic [W-1:0] cnt_o,
   output logic         unf_o
);
   localparam logic [W-1:0] ALL_ONES = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= ALL_ONES;
         unf_o <= 1'b0;
      end else begin
         unf_o <= 1'b0;
         if (load_i) begin
            cnt_o <= ALL_ONES;
         end else if (tick_i) begin
            cnt_o <= cnt_o - 1'b1;
            unf_o <= (cnt_o == '0);
         end
      end
   end
endmodule

// File: rtl/tmr_mode_ctrl.sv
module tmr_mode_ctrl
   import tmr_pkg::*;
#(
   parameter int REG_W       = 8,
   parameter int CNT_W       = 8,
   parameter int PS_W        = 10,
   parameter int TAP_SLOW    = 8,
   parameter int TAP_MID     = 7,
   parameter int TAP_FAST    = 1,
   parameter int SYNC_STAGES = 2,
   parameter int RO_BIT      = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic [PS_W-1:0]  prs_i,
   input  logic             ext_a,
   input  logic             ext_b,
   input  logic             edge_sel_a,
   input  logic             edge_sel_b,
   input  logic             remote_mode,
   output logic [CNT_W-1:0] cnt_a,
   output logic [CNT_W-1:0] cnt_b,
   output logic             unf_a,
   output logic             unf_b
);
   localparam int NCH = 2;
   localparam logic [REG_W-1:0] RO_MASK = REG_W'(1) << RO_BIT;

   if (PS_W <= TAP_SLOW || TAP_SLOW <= TAP_MID || TAP_MID <= TAP_FAST)
      $error("prescaler taps must be ordered and fit inside PS_W");
   if (REG_W < 8 || RO_BIT >= REG_W - 2)
      $error("mode register too narrow for the source field");
   if (SYNC_STAGES < 2)
      $error("synchronizer needs at least two stages");

   logic [REG_W-1:0] mode_q;
   src_e             src;
   logic             div_tick, preload;
   logic [NCH-1:0]   pin, rise, ext_tick, tick;
   logic [CNT_W-1:0] cnt [NCH];
   logic [NCH-1:0]   unf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mode_q <= '0;
      else if (wr_en) mode_q <= wr_data & ~RO_MASK;
   end

   assign rd_data = mode_q | RO_MASK;
   assign src     = src_e'(mode_q[REG_W-1 -: 2]);
   assign preload = wr_en & ~remote_mode;

   assign pin  = {ext_b, ext_a};
   assign rise = {remote_mode ? ~edge_sel_a : edge_sel_b, edge_sel_a};

   tmr_tick_gen #(
      .PS_W(PS_W), .TAP_SLOW(TAP_SLOW), .TAP_MID(TAP_MID), .TAP_FAST(TAP_FAST)
   ) u_tick (
      .clk(clk), .rst_n(rst_n), .prs_i(prs_i), .sel_i(src), .tick_o(div_tick)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      tmr_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
         .clk(clk), .rst_n(rst_n), .pin_i(pin[c]), .rise_i(rise[c]),
         .edge_o(ext_tick[c])
      );

      assign tick[c] = (src == SRC_EXT) ? ext_tick[c] : div_tick;

      tmr_down_cnt #(.W(CNT_W)) u_cnt (
         .clk(clk), .rst_n(rst_n), .load_i(preload), .tick_i(tick[c]),
         .cnt_o(cnt[c]), .unf_o(unf[c])
      );
   end

   assign cnt_a = cnt[0];
   assign cnt_b = cnt[1];
   assign unf_a = unf[0];
   assign unf_b = unf[1];
endmodule

// File: rtl/tmr_mode_ctrl_chk.sv
module tmr_mode_ctrl_chk #(
   parameter int REG_W = 8,
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             remote_mode,
   input logic [REG_W-1:0] rd_data,
   input logic [CNT_W-1:0] cnt_a,
   input logic [CNT_W-1:0] cnt_b,
   input logic             unf_a,
   input logic             unf_b,
   input logic [1:0]       tick
);
   localparam logic [CNT_W-1:0] ONES = '1;

   a_r2_ro_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[1]);

   a_r3_write_preload: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !remote_mode |=> cnt_a == ONES && cnt_b == ONES);

   a_r4_remote_hold: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && remote_mode && !tick[0] |=> $stable(cnt_a));

   a_r10_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      tick[1] && !(wr_en && !remote_mode) |=> cnt_b == $past(cnt_b) - 1'b1);

   a_r10_unf_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      unf_a |-> cnt_a == ONES && $past(cnt_a) == '0);

   a_r10_unf_single: assert property (@(posedge clk) disable iff (!rst_n)
      unf_b |=> !unf_b);
endmodule

bind tmr_mode_ctrl tmr_mode_ctrl_chk #(.REG_W(REG_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .remote_mode(remote_mode),
   .rd_data(rd_data), .cnt_a(cnt_a), .cnt_b(cnt_b), .unf_a(unf_a),
   .unf_b(unf_b), .tick(tick)
);

// File: tb/tmr_mode_ctrl_test.sv
module tmr_mode_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int PS_W = 10;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [7:0]      wr_data = '0;
   logic [7:0]      rd_data;
   logic [PS_W-1:0] prs;
   logic            ext_a = 1'b0, ext_b = 1'b0;
   logic            edge_sel_a = 1'b1, edge_sel_b = 1'b1;
   logic            remote_mode = 1'b0;
   logic [7:0]      cnt_a, cnt_b;
   logic            unf_a, unf_b;

   int vectors = 0;
   int errors  = 0;
   int cycles  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prs <= '0;
      else        prs <= prs + 1'b1;
   end

   tmr_mode_ctrl uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .prs_i(prs), .ext_a(ext_a), .ext_b(ext_b),
      .edge_sel_a(edge_sel_a), .edge_sel_b(edge_sel_b),
      .remote_mode(remote_mode), .cnt_a(cnt_a), .cnt_b(cnt_b),
      .unf_a(unf_a), .unf_b(unf_b)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic write_reg(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_step(output int n);
      logic [7:0] last;
      last = cnt_a;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (cnt_a == last && n < 3000);
   endtask

   task automatic t_reset();
      chk("R1", "rd_data", rd_data, 8'h02);
      chk("R1", "cnt_a", cnt_a, 8'hFF);
      chk("R1", "cnt_b", cnt_b, 8'hFF);
      chk("R1", "unf", {unf_a, unf_b}, 0);
   endtask

   task automatic t_readback();
      write_reg(8'h3D);
      chk("R2", "rd 3D", rd_data, 8'h3F);
      write_reg(8'h00);
      chk("R2", "rd 00", rd_data, 8'h02);
      write_reg(8'hFF);
      chk("R2", "rd FF", rd_data, 8'hFF);
   endtask

   task automatic t_period(input logic [1:0] sel, input int exp, input string req);
      int n;
      write_reg({sel, 6'b0});
      wait_step(n);
      wait_step(n);
      chk(req, "tick period", n, exp);
   endtask

   task automatic t_preload();
      write_reg(8'h80);
      idle(20);
      chk("R3", "counted away", int'(cnt_a != 8'hFF), 1);
      write_reg(8'h81);
      chk("R3", "cnt_a after write", cnt_a, 8'hFF);
      chk("R3", "cnt_b after write", cnt_b, 8'hFF);
   endtask

   task automatic t_collide();
      write_reg(8'h80);
      idle(10);
      do @(negedge clk); while (prs[1:0] != 2'b00);
      wr_en = 1'b1; wr_data = 8'h80;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R11", "preload beats tick", cnt_a, 8'hFF);
   endtask

   task automatic t_wrap();
      int pulses = 0;
      int bad = 0;
      write_reg(8'h80);
      for (int i = 0; i < 1040; i++) begin
         @(negedge clk);
         if (unf_a) begin
            pulses++;
            if (cnt_a != 8'hFF) bad++;
         end
      end
      chk("R10", "underflow pulses", pulses, 1);
      chk("R10", "value at underflow", bad, 0);
   endtask

   task automatic t_ext_normal();
      edge_sel_a = 1'b1; edge_sel_b = 1'b0; remote_mode = 1'b0;
      write_reg(8'hC0);
      ext_a = 1'b1; ext_b = 1'b1;
      idle(5);
      chk("R8", "rise counted A", cnt_a, 8'hFE);
      chk("R8", "rise ignored B", cnt_b, 8'hFF);
      ext_a = 1'b0; ext_b = 1'b0;
      idle(5);
      for (int i = 0; i < 2; i++) begin
         ext_a = 1'b1; ext_b = 1'b1; idle(5);
         ext_a = 1'b0; ext_b = 1'b0; idle(5);
      end
      chk("R8", "three edges A", cnt_a, 8'hFC);
      chk("R8", "three edges B", cnt_b, 8'hFC);
   endtask

   task automatic t_remote();
      edge_sel_a = 1'b1; edge_sel_b = 1'b1;
      write_reg(8'hC0);
      remote_mode = 1'b1;
      ext_b = 1'b1; idle(5);
      chk("R9", "B rise ignored", cnt_b, 8'hFF);
      ext_b = 1'b0; idle(5);
      chk("R9", "B fall counted", cnt_b, 8'hFE);
      ext_a = 1'b1; idle(5);
      ext_a = 1'b0; idle(5);
      chk("R9", "A rising only", cnt_a, 8'hFE);
      write_reg(8'hC4);
      chk("R4", "no preload A", cnt_a, 8'hFE);
      chk("R4", "no preload B", cnt_b, 8'hFE);
      chk("R4", "write taken", rd_data, 8'hC6);
      remote_mode = 1'b0;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
         end
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_readback();
      t_preload();
      t_period(2'b00, 512, "R5");
      t_period(2'b01, 256, "R6");
      t_period(2'b10, 4, "R7");
      t_collide();
      t_wrap();
      t_ext_normal();
      t_remote();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule